// File: doc/BRIEF.md
# HDLC Bit-Serial Transmit Framer

This block turns a stream of bytes into a bit-serial HDLC line signal. Bytes arrive on a ready/valid input that also carries an end-of-frame marker and an abort request. The block advances by one line bit on each cycle in which its bit strobe is high. Each frame gets an opening flag and a 16-bit frame check sequence (FCS), and ends with a closing flag. Inside the data and the FCS, a zero is inserted after every run of five ones, so that the payload can never look like a flag.

When no frame is in progress, the line carries one of three fill patterns chosen by a 2-bit mode input: steady ones, back-to-back flags, or a repeating go-ahead pattern. The go-ahead fill holds the line even while data waits. A frame may start only at the first bit of a fill unit. A one-bit pulse marks the last bit of every closing flag or abort, so a line multiplexer can switch channels on packet boundaries.

Top module: `hdlc_tx_framer`

## Requirements
- R1: While `rst` is high and after it is released, `tx_bit` is 1, `eop` is 0 and `in_ready` is 0 until the first strobe.
- R2: `tx_bit` and `eop` change only on a clock edge where `bit_en` is high, one line bit per strobe. `in_ready` is high only while `bit_en` is high.
- R3: A frame is sent as follows: the opening flag 0x7E, then every accepted byte LSB first, then the FCS, then the closing flag 0x7E. Flag bits go out LSB first, giving the line sequence 0,1,1,1,1,1,1,0.
- R4: After five consecutive ones in the data or FCS bits, one extra 0 is sent. This also applies when the fifth one is the last FCS bit, in which case the 0 precedes the closing flag. Flag, abort and fill bits are never stuffed, and they break a run of ones.
- R5: The FCS register starts at 0xFFFF and is updated with every data bit using x^16+x^12+x^5+1 in LSB-first (reflected) form. Its ones-complement is sent low bit first. The nine ASCII bytes "123456789" give the FCS value 0x906E.
- R6: A byte accepted with `in_abort` high is not sent. In its place the line carries eight ones, after which fill resumes.
- R7: If `in_valid` is low at a point where the next byte of a frame is needed, the frame is aborted with eight ones.
- R8: Fill mode 2'b00 sends steady ones in 8-bit units. A frame starts at the first bit of a unit when `in_valid` is high.
- R9: Fill modes 2'b01 and 2'b11 send repeated 0x7E flags in 8-bit units. A frame starts at the first bit of a unit when `in_valid` is high.
- R10: Fill mode 2'b10 sends a 9-bit go-ahead unit: 0x7F LSB first followed by a 0. No frame is started in this mode even when data is valid. A frame starts at the first unit boundary after the mode changes to another value.
- R11: `eop` is high for exactly one line bit, on the last bit of a closing flag or of an abort. It is low on every other bit, including a stuffed 0.
- R12: `fill_mode` is sampled only at the first bit of each fill unit. A change in the middle of a unit takes effect at the next unit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit strobe: one line bit per high cycle |
| fill_mode | input | 2 | Interframe fill select: 00 ones, 01/11 flags, 10 go-ahead |
| in_valid | input | 1 | Byte available |
| in_data | input | 8 | Byte to send, bit 0 first |
| in_last | input | 1 | Byte is the last of its frame |
| in_abort | input | 1 | Send an abort in place of this byte |
| in_ready | output | 1 | Byte is taken on this edge |
| tx_bit | output | 1 | Serial line output |
| eop | output | 1 | End-of-packet pulse on the last bit of a closing flag or abort |

## Verification
Frames are sent from both ones fill and flag fill, and back to back. Payloads full of ones force stuffing in the data and across byte edges. The "123456789" frame pins the FCS against a known value. Abort-tagged bytes and a starved source show that the abort replaces the byte and that the end pulse lands on the eighth one. A gated strobe with gaps shows that the line holds between strobes. Go-ahead with queued data, and a mode change in the middle of a unit, separate boundary-sampled mode handling from an immediate reaction.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

    localparam int          IDX_W     = 5;
    localparam int          FCS_W     = 16;
    localparam logic [7:0]  FLAG_BYTE = 8'h7E;
    localparam logic [15:0] FCS_POLY  = 16'h8408;  // reflected x^16+x^12+x^5+1
    localparam logic [15:0] FCS_INIT  = 16'hFFFF;

    typedef enum logic [1:0] {
        FILL_ONES    = 2'b00,
        FILL_FLAGS   = 2'b01,
        FILL_GOAHEAD = 2'b10,
        FILL_FLAGS_B = 2'b11
    } fill_mode_e;

    typedef enum logic [2:0] {
        PH_FILL,
        PH_OPEN,
        PH_DATA,
        PH_FCS,
        PH_CLOSE,
        PH_ABORT
    } phase_e;

    // index of the final bit of a unit in a given phase
    function automatic logic [IDX_W-1:0] phase_last(phase_e p, fill_mode_e m);
        logic [IDX_W-1:0] r;
        case (p)
            PH_FILL: r = (m == FILL_GOAHEAD) ? IDX_W'(8) : IDX_W'(7);
            PH_FCS:  r = IDX_W'(FCS_W - 1);
            default: r = IDX_W'(7);
        endcase
        return r;
    endfunction

    function automatic logic is_stuffable(phase_e p);
        return (p == PH_DATA) || (p == PH_FCS);
    endfunction

endpackage

// File: rtl/hdlc_tx_fcs.sv
module hdlc_tx_fcs #(
    parameter int          WIDTH = 16,
    parameter logic [WIDTH-1:0] POLY = 16'h8408,
    parameter logic [WIDTH-1:0] INIT = 16'hFFFF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             shift,
    input  logic             din,
    output logic [WIDTH-1:0] fcs_out
);
    logic [WIDTH-1:0] crc_q;
    logic [WIDTH-1:0] crc_n;
    logic             fb;

    assign fb = crc_q[0] ^ din;

    // one reflected LFSR step, tap by tap
    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_tap
            if (i == WIDTH - 1) begin : g_top
                assign crc_n[i] = fb & POLY[i];
            end else begin : g_mid
                assign crc_n[i] = crc_q[i+1] ^ (fb & POLY[i]);
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            crc_q <= INIT;
        end else if (shift) begin
            crc_q <= crc_n;
        end
    end

    assign fcs_out = ~crc_q;
endmodule

// File: rtl/hdlc_tx_fill.sv
module hdlc_tx_fill
    import hdlc_tx_pkg::*;
(
    input  fill_mode_e       mode,
    input  logic [IDX_W-1:0] idx,
    output logic             fill_bit
);
    always_comb begin
        case (mode)
            FILL_ONES:    fill_bit = 1'b1;
            FILL_GOAHEAD: fill_bit = (idx < IDX_W'(7));
            default:      fill_bit = FLAG_BYTE[idx[2:0]];
        endcase
    end
endmodule

// File: rtl/hdlc_tx_stuff.sv
module hdlc_tx_stuff #(
    parameter int RUN = 5,
    localparam int CNT_W = $clog2(RUN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_en,
    input  logic             src_bit,
    input  logic             stuffable,
    output logic             insert,
    output logic [CNT_W-1:0] ones_cnt
);
    logic [CNT_W-1:0] ones_q;

    assign insert   = (ones_q == CNT_W'(RUN));
    assign ones_cnt = ones_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ones_q <= '0;
        end else if (bit_en) begin
            if (insert) begin
                ones_q <= '0;
            end else if (stuffable && src_bit) begin
                ones_q <= ones_q + CNT_W'(1);
            end else begin
                ones_q <= '0;
            end
        end
    end
endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
    import hdlc_tx_pkg::*;
#(
    parameter int STUFF_RUN = 5,
    localparam int ONES_W = $clog2(STUFF_RUN + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_en,
    input  logic [1:0] fill_mode,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_last,
    input  logic       in_abort,
    output logic       in_ready,
    output logic       tx_bit,
    output logic       eop
);
    phase_e           phase_q, eff_phase, phase_n;
    logic [IDX_W-1:0] idx_q, idx_n, last_idx;
    fill_mode_e       mode_q, mode_in, eff_mode;
    logic [7:0]       byte_q;
    logic             last_q;

    logic             unit_start, start_frame, at_last, load_pt;
    logic             src_bit, fill_bit, stuffable, insert, advance, end_pkt;
    logic [FCS_W-1:0] fcs_val;
    logic [ONES_W-1:0] stuff_ones;

    assign mode_in     = fill_mode_e'(fill_mode);
    assign unit_start  = (phase_q == PH_FILL) && (idx_q == '0);
    assign start_frame = unit_start && (mode_in != FILL_GOAHEAD) && in_valid;
    assign eff_phase   = start_frame ? PH_OPEN : phase_q;
    assign eff_mode    = unit_start ? mode_in : mode_q;
    assign last_idx    = phase_last(eff_phase, eff_mode);
    assign at_last     = (idx_q == last_idx);
    assign stuffable   = is_stuffable(eff_phase);
    assign advance     = bit_en && !insert;
    assign load_pt     = at_last &&
                         ((eff_phase == PH_OPEN) || ((eff_phase == PH_DATA) && !last_q));
    assign in_ready    = advance && load_pt;
    assign end_pkt     = at_last && ((eff_phase == PH_CLOSE) || (eff_phase == PH_ABORT));

    hdlc_tx_fill u_fill (
        .mode     (eff_mode),
        .idx      (idx_q),
        .fill_bit (fill_bit)
    );

    hdlc_tx_fcs #(
        .WIDTH (FCS_W),
        .POLY  (FCS_POLY),
        .INIT  (FCS_INIT)
    ) u_fcs (
        .clk     (clk),
        .rst     (rst),
        .clear   (advance && (eff_phase == PH_OPEN)),
        .shift   (advance && (eff_phase == PH_DATA)),
        .din     (src_bit),
        .fcs_out (fcs_val)
    );

    hdlc_tx_stuff #(.RUN(STUFF_RUN)) u_stuff (
        .clk       (clk),
        .rst       (rst),
        .bit_en    (bit_en),
        .src_bit   (src_bit),
        .stuffable (stuffable),
        .insert    (insert),
        .ones_cnt  (stuff_ones)
    );

    // bit selected by the current position
    always_comb begin
        case (eff_phase)
            PH_FILL:           src_bit = fill_bit;
            PH_OPEN, PH_CLOSE: src_bit = FLAG_BYTE[idx_q[2:0]];
            PH_DATA:           src_bit = byte_q[idx_q[2:0]];
            PH_FCS:            src_bit = fcs_val[idx_q[3:0]];
            default:           src_bit = 1'b1;
        endcase
    end

    // position after a non-stuffed bit
    always_comb begin
        phase_n = eff_phase;
        idx_n   = idx_q + IDX_W'(1);
        if (at_last) begin
            idx_n = '0;
            case (eff_phase)
                PH_OPEN:  phase_n = (!in_valid || in_abort) ? PH_ABORT : PH_DATA;
                PH_DATA: begin
                    if (last_q) phase_n = PH_FCS;
                    else        phase_n = (!in_valid || in_abort) ? PH_ABORT : PH_DATA;
                end
                PH_FCS:   phase_n = PH_CLOSE;
                default:  phase_n = PH_FILL;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_FILL;
            idx_q   <= '0;
            mode_q  <= FILL_ONES;
            byte_q  <= '0;
            last_q  <= 1'b0;
            tx_bit  <= 1'b1;
            eop     <= 1'b0;
        end else if (bit_en) begin
            tx_bit <= insert ? 1'b0 : src_bit;
            eop    <= advance && end_pkt;
            if (advance) begin
                phase_q <= phase_n;
                idx_q   <= idx_n;
                if (unit_start && !start_frame) begin
                    mode_q <= mode_in;
                end
                if (in_ready && in_valid && !in_abort) begin
                    byte_q <= in_data;
                    last_q <= in_last;
                end
            end
        end
    end
endmodule

// File: rtl/hdlc_tx_framer_chk.sv
module hdlc_tx_framer_chk
    import hdlc_tx_pkg::*;
#(
    parameter int STUFF_RUN = 5,
    localparam int ONES_W = $clog2(STUFF_RUN + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              bit_en,
    input logic [1:0]        fill_mode,
    input logic              in_ready,
    input logic              tx_bit,
    input logic              eop,
    input logic [ONES_W-1:0] ones_cnt,
    input phase_e            phase_q,
    input logic [IDX_W-1:0]  idx_q
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (tx_bit && !eop));

    // R2
    line_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> ($stable(tx_bit) && $stable(eop)));

    // R2
    ready_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> bit_en);

    // R4
    stuff_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_en && ones_cnt == ONES_W'(STUFF_RUN)) |=> !tx_bit);

    // R11
    eop_single_chk: assert property (@(posedge clk) disable iff (rst)
        (eop && bit_en) |=> !eop);

    // R10
    goahead_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_en && phase_q == PH_FILL && idx_q == '0 && fill_mode == 2'b10)
        |=> (phase_q == PH_FILL));
endmodule

bind hdlc_tx_framer hdlc_tx_framer_chk #(.STUFF_RUN(STUFF_RUN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bit_en    (bit_en),
    .fill_mode (fill_mode),
    .in_ready  (in_ready),
    .tx_bit    (tx_bit),
    .eop       (eop),
    .ones_cnt  (stuff_ones),
    .phase_q   (phase_q),
    .idx_q     (idx_q)
);

// File: tb/tb_hdlc_tx_framer.sv
module tb_hdlc_tx_framer;

    typedef struct {
        logic  b;
        logic  e;
        string tag;
    } exp_t;

    typedef struct {
        logic [7:0] d;
        logic       last;
        logic       abrt;
    } src_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic [1:0] fill_mode = 2'b00;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_last = 1'b0;
    logic       in_abort = 1'b0;
    logic       in_ready, tx_bit, eop;

    exp_t       exp_q[$];
    src_t       src_q[$];
    logic [7:0] fq[$];
    string      cur_tag = "R8";
    int         n_chk = 0;
    int         n_fail = 0;
    int         sb_ones = 0;
    int         cyc = 0;
    logic       en_q = 1'b0;
    logic       hs = 1'b0;
    logic       prev_tx = 1'b1;
    logic       prev_eop = 1'b0;

    always #2.5 clk = ~clk;

    hdlc_tx_framer dut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .fill_mode(fill_mode),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_abort(in_abort), .in_ready(in_ready), .tx_bit(tx_bit), .eop(eop)
    );

    task automatic push_exp(input logic b, input logic e);
        exp_t it;
        it.b = b; it.e = e; it.tag = cur_tag;
        exp_q.push_back(it);
    endtask

    // bench stuffing model of R4
    task automatic emit(input logic b, input logic st, input logic e);
        if (sb_ones == 5) begin
            push_exp(1'b0, 1'b0);
            sb_ones = 0;
        end
        push_exp(b, e);
        sb_ones = (st && b) ? sb_ones + 1 : 0;
    endtask

    task automatic push_flag(input logic e);
        for (int i = 0; i < 8; i++) emit(((8'h7E >> i) & 1) != 0, 1'b0, e && (i == 7));
    endtask

    task automatic push_fill(input logic [1:0] m, input int units);
        for (int u = 0; u < units; u++) begin
            if (m == 2'b00)      for (int i = 0; i < 8; i++) emit(1'b1, 1'b0, 1'b0);
            else if (m == 2'b10) for (int i = 0; i < 9; i++) emit(i < 7, 1'b0, 1'b0);
            else                 push_flag(1'b0);
        end
    endtask

    task automatic push_abort();
        for (int i = 0; i < 8; i++) emit(1'b1, 1'b0, i == 7);
    endtask

    // frame from fq; abort_at < 0 means none; underrun drops the end marker
    task automatic frame(input int abort_at, input logic underrun, input logic add_src);
        logic [15:0] crc;
        int          n;
        src_t        s;
        n = (abort_at >= 0) ? abort_at + 1 : fq.size();
        if (add_src) begin
            for (int i = 0; i < n; i++) begin
                s.d = fq[i];
                s.abrt = (i == abort_at);
                s.last = (abort_at < 0) && !underrun && (i == n - 1);
                src_q.push_back(s);
            end
        end
        crc = 16'hFFFF;
        push_flag(1'b0);
        for (int i = 0; i < n; i++) begin
            if (i == abort_at) begin
                push_abort();
                return;
            end
            for (int k = 0; k < 8; k++) emit(fq[i][k], 1'b1, 1'b0);
            crc = crc ^ {8'h00, fq[i]};
            for (int k = 0; k < 8; k++) crc = crc[0] ? ((crc >> 1) ^ 16'h8408) : (crc >> 1);
        end
        if (underrun) begin
            push_abort();
            return;
        end
        crc = ~crc;
        for (int k = 0; k < 16; k++) emit(crc[k], 1'b1, 1'b0);
        push_flag(1'b1);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(posedge clk);
    endtask

    // stimulus and monitor, acting on the falling edge
    initial begin
        exp_t it;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (en_q) begin
                    if (exp_q.size() == 0) begin
                        n_chk++; n_fail++;
                        $display("FAIL R2 unexpected strobe: tx_bit=%0b exp none", tx_bit);
                    end else begin
                        it = exp_q.pop_front();
                        n_chk++;
                        if (tx_bit !== it.b || eop !== it.e) begin
                            n_fail++;
                            $display("FAIL %s cyc %0d: tx_bit=%0b eop=%0b exp tx_bit=%0b eop=%0b",
                                     it.tag, cyc, tx_bit, eop, it.b, it.e);
                        end
                    end
                end else begin
                    n_chk++;
                    if (tx_bit !== prev_tx || eop !== prev_eop) begin
                        n_fail++;
                        $display("FAIL R2 hold: tx_bit=%0b eop=%0b exp %0b %0b",
                                 tx_bit, eop, prev_tx, prev_eop);
                    end
                end
                if (hs) void'(src_q.pop_front());
            end
            prev_tx  = tx_bit;
            prev_eop = eop;
            cyc++;
            en_q   = !rst && (exp_q.size() > 0) && (cyc % 7 != 3);
            bit_en = en_q;
            if (src_q.size() > 0) begin
                in_valid = 1'b1;
                in_data  = src_q[0].d;
                in_last  = src_q[0].last;
                in_abort = src_q[0].abrt;
            end else begin
                in_valid = 1'b0; in_data = 8'h00; in_last = 1'b0; in_abort = 1'b0;
            end
            #1;
            hs = in_valid && in_ready;
            if (!rst && !en_q && in_ready) begin
                n_chk++; n_fail++;
                $display("FAIL R2 in_ready=%0b without strobe exp 0", in_ready);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish exp done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        // R1 state after reset
        n_chk++;
        if (tx_bit !== 1'b1 || eop !== 1'b0 || in_ready !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset: tx_bit=%0b eop=%0b in_ready=%0b exp 1 0 0",
                     tx_bit, eop, in_ready);
        end
        @(posedge clk);

        // R8 ones fill, then a frame from ones fill
        fill_mode = 2'b00; cur_tag = "R8";
        push_fill(2'b00, 2); drain();
        cur_tag = "R3"; fq = '{8'h01, 8'h02}; frame(-1, 1'b0, 1'b1); drain();
        cur_tag = "R8"; push_fill(2'b00, 1); drain();

        // R9 flag fill, R5 known FCS, R4 dense ones back to back
        fill_mode = 2'b01; cur_tag = "R9";
        push_fill(2'b01, 2); drain();
        cur_tag = "R5"; fq = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
        frame(-1, 1'b0, 1'b1); drain();
        cur_tag = "R4"; fq = '{8'hFF, 8'hFF, 8'h7E, 8'hF8}; frame(-1, 1'b0, 1'b1); drain();
        cur_tag = "R4"; fq = '{8'h3F, 8'hFC, 8'h1F}; frame(-1, 1'b0, 1'b1); drain();
        fill_mode = 2'b11; cur_tag = "R9";
        push_fill(2'b11, 1); drain();

        // R12 mode change in the middle of a flag unit
        fill_mode = 2'b01; cur_tag = "R12";
        for (int i = 0; i < 4; i++) emit(((8'h7E >> i) & 1) != 0, 1'b0, 1'b0);
        drain();
        fill_mode = 2'b00;
        for (int i = 4; i < 8; i++) emit(((8'h7E >> i) & 1) != 0, 1'b0, 1'b0);
        push_fill(2'b00, 1); drain();

        // R6 abort request on a byte, R11 pulse on its last one
        fill_mode = 2'b01; cur_tag = "R6";
        fq = '{8'h55, 8'hAA}; frame(1, 1'b0, 1'b1); drain();
        cur_tag = "R11"; push_fill(2'b01, 1); drain();
        cur_tag = "R6"; fq = '{8'h12}; frame(0, 1'b0, 1'b1); drain();

        // R7 starved source
        cur_tag = "R7"; fq = '{8'hF8, 8'h1F}; frame(-1, 1'b1, 1'b1); drain();
        push_fill(2'b01, 1); drain();

        // R10 go-ahead ignores queued data until the mode changes
        fill_mode = 2'b10; cur_tag = "R10";
        push_fill(2'b10, 2); drain();
        fq = '{8'h3C, 8'hC3};
        for (int i = 0; i < 2; i++) begin
            src_t s;
            s.d = fq[i]; s.abrt = 1'b0; s.last = (i == 1);
            src_q.push_back(s);
        end
        push_fill(2'b10, 2); drain();
        fill_mode = 2'b01;
        frame(-1, 1'b0, 1'b0); drain();
        cur_tag = "R11"; push_fill(2'b01, 1); drain();

        repeat (3) @(posedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule